// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits between an 8-bit CPU bus, a video fetch bus and the memories on a game cartridge. It watches CPU writes to the upper half of the address space and uses the write address range and the parity of address bit 0 to load its control state. That state is a bank-select byte, six pattern-bank registers, two program-bank registers, a nametable mirroring control and a work-RAM protection state.

All address translation is combinational. A 16-bit CPU address becomes a banked program-ROM address made of 8 KiB banks. A 14-bit video pattern address becomes a banked pattern address made of 1 KiB banks. Work-RAM read and write strobes are gated by the protection state. The current mirroring arrangement is driven out for the nametable logic. The scanline interrupt counter, the memory arrays and the bus timing live elsewhere.

Top module: `cart_bank_mapper`

## Requirements
- R1: While `rst_n` is low and after it rises, the program layout and the pattern layout are both 0 and every bank register holds 0. The write target is the register at index 0, work RAM is disabled (both strobes low), and `mirror_mode` equals `mirror_cfg`.
- R2: A CPU write with `cpu_addr[15:13]`=100 and `cpu_addr[0]`=0 loads the bank-select byte. Data bit 7 picks the pattern layout, bit 6 picks the program layout, and bits 2:0 pick the target register. Indices 0–5 are pattern banks and indices 6–7 are program banks.
- R3: A CPU write with `cpu_addr[15:13]`=100 and `cpu_addr[0]`=1 stores the data byte into the register named by the last bank-select write.
- R4: A value stored into register 0 or register 1 has bit 0 cleared. A value stored into register 6 or register 7 keeps only its low `PRG_BANK_W` bits (6 by default).
- R5: `prg_addr` is {bank, `cpu_addr[12:0]`}. The window is chosen by `cpu_addr[14:13]`. With program layout 0: 00 uses register 6, 01 uses register 7, 10 uses bank `PRG_BANKS`-2 and 11 uses bank `PRG_BANKS`-1. With layout 1, windows 00 and 10 trade places. `prg_rom_cs` equals `cpu_addr[15]`.
- R6: `chr_addr` is {bank, `ppu_addr[9:0]`}. Let the half be `ppu_addr[12]` XOR the pattern layout. In half 0, `ppu_addr[11]` picks register 0 or 1, and `ppu_addr[10]` supplies the bank LSB. In half 1, `ppu_addr[11:10]` picks registers 2–5. `chr_cs` is the inverse of `ppu_addr[13]`.
- R7: `mirror_mode` encodes 00 vertical, 01 horizontal, 10 single-screen and 11 four-screen. A write with `cpu_addr[15:13]`=101 and `cpu_addr[0]`=0 sets vertical (data bit 0 = 0) or horizontal (bit 0 = 1). It does so only while the current mode is vertical or horizontal; modes 10 and 11 never change until reset.
- R8: A write with `cpu_addr[15:13]`=101 and `cpu_addr[0]`=1 sets the RAM state. Data bit 6 set gives read-only. Otherwise bit 7 set gives read-write. Otherwise RAM is disabled. In `cpu_addr[15:13]`=011, `wram_rd_en` follows `cpu_rd` unless RAM is disabled, and `wram_wr_en` follows `cpu_wr` only when RAM is read-write.
- R9: CPU writes to 0x4020–0x7FFF and to 0xC000–0xFFFF leave every mapping state (banks, layouts, mirroring, RAM state) unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mirror_cfg | input | 2 | Cartridge mirroring arrangement loaded at reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the clock edge |
| cpu_rd | input | 1 | CPU read strobe |
| prg_addr | output | PRG_BANK_W+13 | Banked program-ROM address |
| prg_rom_cs | output | 1 | Program-ROM select |
| wram_rd_en | output | 1 | Work-RAM read enable |
| wram_wr_en | output | 1 | Work-RAM write enable |
| ppu_addr | input | 14 | Video fetch address |
| chr_addr | output | 18 | Banked pattern address |
| chr_cs | output | 1 | Pattern memory select |
| mirror_mode | output | 2 | Nametable mirroring arrangement |

## Verification
The bench aims at each program window in both layouts. A design that swapped the wrong pair of windows, or computed the fixed banks from the wrong end of the ROM, would put the wrong bank number in the top bits of `prg_addr`. It stores values with bit 0 set into the 2 KiB pattern registers and oversized values into the program registers: missing masks show up as odd bank numbers or bits above the sixth. It also covers fixed mirroring under a mirroring write, protect-wins-over-enable for work RAM, and writes to the ignored ranges. Each of these would show as a changed mirroring output, a spurious write strobe or a moved bank.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   typedef enum logic [1:0] {
      MIR_VERT = 2'b00,
      MIR_HORZ = 2'b01,
      MIR_ONE  = 2'b10,
      MIR_FOUR = 2'b11
   } mirror_t;

   typedef enum logic [1:0] {
      RAM_OFF = 2'b00,
      RAM_RO  = 2'b01,
      RAM_RW  = 2'b10
   } ram_state_t;

   localparam int unsigned CHR_BANK_W = 8;
   localparam int unsigned NUM_CHR_REGS = 6;
   localparam int unsigned NUM_PRG_REGS = 2;
endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile
   import cbm_pkg::*;
#(
   parameter int unsigned PRG_BANK_W = 6
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [1:0]                             mirror_cfg,
   input  logic                                   wr_en,
   input  logic [2:0]                             addr_hi,
   input  logic                                   addr_odd,
   input  logic [7:0]                             data,
   output logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_q,
   output logic [NUM_PRG_REGS-1:0][PRG_BANK_W-1:0] prg_q,
   output logic                                   prg_mode,
   output logic                                   chr_mode,
   output mirror_t                                mirror,
   output ram_state_t                             ram_state
);
   logic [2:0] target;
   logic       wr_bank;
   logic       wr_ctrl;

   assign wr_bank = wr_en && (addr_hi == 3'b100);
   assign wr_ctrl = wr_en && (addr_hi == 3'b101);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target    <= 3'd0;
         prg_mode  <= 1'b0;
         chr_mode  <= 1'b0;
         mirror    <= mirror_t'(mirror_cfg);
         ram_state <= RAM_OFF;
      end else begin
         if (wr_bank && !addr_odd) begin
            chr_mode <= data[7];
            prg_mode <= data[6];
            target   <= data[2:0];
         end
         if (wr_ctrl && !addr_odd && !mirror[1])
            mirror <= data[0] ? MIR_HORZ : MIR_VERT;
         if (wr_ctrl && addr_odd) begin
            if (data[6])      ram_state <= RAM_RO;
            else if (data[7]) ram_state <= RAM_RW;
            else              ram_state <= RAM_OFF;
         end
      end
   end

   for (genvar i = 0; i < NUM_CHR_REGS; i++) begin : g_chr
      localparam logic [CHR_BANK_W-1:0] KEEP = (i < 2) ? 8'hFE : 8'hFF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chr_q[i] <= '0;
         else if (wr_bank && addr_odd && (target == 3'(i)))
            chr_q[i] <= data & KEEP;
      end
   end

   for (genvar j = 0; j < NUM_PRG_REGS; j++) begin : g_prg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prg_q[j] <= '0;
         else if (wr_bank && addr_odd && (target == 3'(j + NUM_CHR_REGS)))
            prg_q[j] <= data[PRG_BANK_W-1:0];
      end
   end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
   parameter int unsigned PRG_BANKS  = 64,
   parameter int unsigned PRG_BANK_W = 6,
   localparam int unsigned PRG_AW    = PRG_BANK_W + 13
) (
   input  logic [14:0]           cpu_addr,
   input  logic [PRG_BANK_W-1:0] bank_a,
   input  logic [PRG_BANK_W-1:0] bank_b,
   input  logic                  prg_mode,
   output logic [PRG_AW-1:0]     prg_addr
);
   localparam logic [PRG_BANK_W-1:0] LAST_BANK   = PRG_BANK_W'(PRG_BANKS - 1);
   localparam logic [PRG_BANK_W-1:0] SECOND_BANK = PRG_BANK_W'(PRG_BANKS - 2);

   logic [PRG_BANK_W-1:0] bank;

   always_comb begin
      unique case (cpu_addr[14:13])
         2'b00:   bank = prg_mode ? SECOND_BANK : bank_a;
         2'b01:   bank = bank_b;
         2'b10:   bank = prg_mode ? bank_a : SECOND_BANK;
         default: bank = LAST_BANK;
      endcase
   end

   assign prg_addr = {bank, cpu_addr[12:0]};
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
   import cbm_pkg::*;
(
   input  logic [12:0]                             ppu_addr,
   input  logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_q,
   input  logic                                    chr_mode,
   output logic [CHR_BANK_W+9:0]                   chr_addr
);
   logic                  half;
   logic [CHR_BANK_W-1:0] bank;

   assign half = ppu_addr[12] ^ chr_mode;

   always_comb begin
      if (!half)
         // big windows hold even banks, so OR inserts the 1 KiB half select
         bank = chr_q[ppu_addr[11]] | {{(CHR_BANK_W-1){1'b0}}, ppu_addr[10]};
      else
         bank = chr_q[3'd2 + {1'b0, ppu_addr[11:10]}];
   end

   assign chr_addr = {bank, ppu_addr[9:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int unsigned PRG_BANKS  = 64,
   parameter int unsigned PRG_BANK_W = 6,
   localparam int unsigned PRG_AW    = PRG_BANK_W + 13,
   localparam int unsigned CHR_AW    = CHR_BANK_W + 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mirror_cfg,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_data,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   output logic [PRG_AW-1:0] prg_addr,
   output logic              prg_rom_cs,
   output logic              wram_rd_en,
   output logic              wram_wr_en,
   input  logic [13:0]       ppu_addr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_cs,
   output logic [1:0]        mirror_mode
);
   if (PRG_BANK_W < 1 || PRG_BANK_W > 8) begin : g_bad_width
      $error("PRG_BANK_W must lie in 1..8");
   end
   if (PRG_BANKS < 2 || PRG_BANKS > (1 << PRG_BANK_W)) begin : g_bad_count
      $error("PRG_BANKS must lie in 2..2**PRG_BANK_W");
   end

   logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_q;
   logic [NUM_PRG_REGS-1:0][PRG_BANK_W-1:0] prg_q;
   logic       prg_mode;
   logic       chr_mode;
   mirror_t    mirror;
   ram_state_t ram_state;
   logic       in_ram;

   cbm_regfile #(.PRG_BANK_W(PRG_BANK_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .mirror_cfg(mirror_cfg),
      .wr_en     (cpu_wr),
      .addr_hi   (cpu_addr[15:13]),
      .addr_odd  (cpu_addr[0]),
      .data      (cpu_data),
      .chr_q     (chr_q),
      .prg_q     (prg_q),
      .prg_mode  (prg_mode),
      .chr_mode  (chr_mode),
      .mirror    (mirror),
      .ram_state (ram_state)
   );

   cbm_prg_map #(.PRG_BANKS(PRG_BANKS), .PRG_BANK_W(PRG_BANK_W)) u_prg (
      .cpu_addr(cpu_addr[14:0]),
      .bank_a  (prg_q[0]),
      .bank_b  (prg_q[1]),
      .prg_mode(prg_mode),
      .prg_addr(prg_addr)
   );

   cbm_chr_map u_chr (
      .ppu_addr(ppu_addr[12:0]),
      .chr_q   (chr_q),
      .chr_mode(chr_mode),
      .chr_addr(chr_addr)
   );

   assign in_ram      = (cpu_addr[15:13] == 3'b011);
   assign wram_rd_en  = cpu_rd && in_ram && (ram_state != RAM_OFF);
   assign wram_wr_en  = cpu_wr && in_ram && (ram_state == RAM_RW);
   assign prg_rom_cs  = cpu_addr[15];
   assign chr_cs      = ~ppu_addr[13];
   assign mirror_mode = mirror;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
   parameter int unsigned PRG_BANKS  = 64,
   parameter int unsigned PRG_BANK_W = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [15:0]           cpu_addr,
   input logic                  cpu_wr,
   input logic [PRG_BANK_W+12:0] prg_addr,
   input logic [13:0]           ppu_addr,
   input logic [17:0]           chr_addr,
   input logic [1:0]            mirror_mode,
   input logic                  wram_wr_en,
   input logic                  prg_mode,
   input logic                  chr_mode
);
   a_r5_last_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PRG_BANK_W+12:13] == PRG_BANK_W'(PRG_BANKS - 1)));

   a_r5_second_bank: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_addr[15:13] == 3'b110 && !prg_mode) || (cpu_addr[15:13] == 3'b100 && prg_mode))
      |-> (prg_addr[PRG_BANK_W+12:13] == PRG_BANK_W'(PRG_BANKS - 2)));

   a_r6_big_window_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (ppu_addr[12] == chr_mode) |-> (chr_addr[10] == ppu_addr[10]));

   a_r7_fixed_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      mirror_mode[1] |=> $stable(mirror_mode));

   a_r8_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wram_wr_en |-> (cpu_wr && cpu_addr[15:13] == 3'b011));

   a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (cpu_addr[15:14] == 2'b11 || cpu_addr[15:13] == 3'b010 || cpu_addr[15:13] == 3'b011))
      |=> ($stable(prg_mode) && $stable(chr_mode) && $stable(mirror_mode)));
endmodule

bind cart_bank_mapper cbm_checker #(.PRG_BANKS(PRG_BANKS), .PRG_BANK_W(PRG_BANK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_wr     (cpu_wr),
   .prg_addr   (prg_addr),
   .ppu_addr   (ppu_addr),
   .chr_addr   (chr_addr),
   .mirror_mode(mirror_mode),
   .wram_wr_en (wram_wr_en),
   .prg_mode   (prg_mode),
   .chr_mode   (chr_mode)
);

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mirror_cfg = 2'b00;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [18:0] prg_addr;
   logic        prg_rom_cs;
   logic        wram_rd_en;
   logic        wram_wr_en;
   logic [13:0] ppu_addr = 14'h0000;
   logic [17:0] chr_addr;
   logic        chr_cs;
   logic [1:0]  mirror_mode;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cart_bank_mapper uut (
      .clk(clk), .rst_n(rst_n), .mirror_cfg(mirror_cfg),
      .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .prg_addr(prg_addr), .prg_rom_cs(prg_rom_cs),
      .wram_rd_en(wram_rd_en), .wram_wr_en(wram_wr_en),
      .ppu_addr(ppu_addr), .chr_addr(chr_addr), .chr_cs(chr_cs),
      .mirror_mode(mirror_mode)
   );

   // {write addr, data, write addr, data, probe addr, expected prg_addr}
   localparam int NV = 12;
   localparam logic [82:0] VEC [NV] = '{
      {16'h8000, 8'h06, 16'h8001, 8'h05, 16'h8123, 19'h0A123}, // R5 R6 reg, layout 0
      {16'h8000, 8'h07, 16'h8001, 8'hFF, 16'hA010, 19'h7E010}, // R4 mask to 6 bits
      {16'h8000, 8'h47, 16'h8001, 8'h09, 16'hC004, 19'h0A004}, // R5 layout 1, reg 6 at C000
      {16'h8000, 8'h46, 16'h8001, 8'h0C, 16'h8001, 19'h7C001}, // R5 layout 1, fixed at 8000
      {16'h8000, 8'h06, 16'h9FFF, 8'h21, 16'h9ABC, 19'h43ABC}, // R3 odd at range top
      {16'h9FFE, 8'h07, 16'h8003, 8'h80, 16'hBFFF, 19'h01FFF}, // R4 high bits dropped
      {16'h8000, 8'h00, 16'h8001, 8'h00, 16'hE005, 19'h7E005}, // R5 last bank
      {16'h8000, 8'h40, 16'h8001, 8'h00, 16'hC002, 19'h42002}, // R2 layout bit 6
      {16'h8000, 8'h40, 16'h8001, 8'h00, 16'hA100, 19'h00100}, // R5 window 01
      {16'h5000, 8'h06, 16'h4021, 8'hFF, 16'h8000, 19'h7C000}, // R9 low range
      {16'hC000, 8'h00, 16'hE001, 8'h00, 16'hC000, 19'h42000}, // R9 upper pairs
      {16'h6000, 8'h80, 16'h7001, 8'h47, 16'h8000, 19'h7C000}  // R9 work RAM range
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic do_reset(input logic [1:0] cfg);
      @(negedge clk);
      mirror_cfg = cfg; rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic prg_probe(input string tag, input logic [15:0] a, input logic [18:0] exp);
      cpu_addr = a; #1;
      check(tag, 32'(prg_addr), 32'(exp));
   endtask

   task automatic chr_probe(input string tag, input logic [13:0] a, input logic [17:0] exp);
      ppu_addr = a; #1;
      check(tag, 32'(chr_addr), 32'(exp));
   endtask

   task automatic ram_probe(input string tag, input logic rd, input logic wr,
                            input logic exp_rd, input logic exp_wr);
      @(negedge clk);
      cpu_addr = 16'h6100; cpu_rd = rd; cpu_wr = wr; #1;
      check(tag, {30'd0, wram_rd_en, wram_wr_en}, {30'd0, exp_rd, exp_wr});
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset(2'b00);
      prg_probe("R1 reset window 8000", 16'h8000, 19'h00000);
      prg_probe("R1 reset fixed C000", 16'hC000, 19'h7C000);
      chr_probe("R1 reset chr", 14'h1234, 18'h00234);
      check("R1 reset mirror", 32'(mirror_mode), 32'd0);
      ram_probe("R1 reset ram off", 1'b1, 1'b1, 1'b0, 1'b0);
      check("R5 rom select", 32'(prg_rom_cs), 32'd0);
      // R1 target is register 0 after reset, R4 even forcing
      cpu_write(16'h8001, 8'h07);
      chr_probe("R1 default target", 14'h0000, 18'h01800);

      // table walk
      for (int i = 0; i < NV; i++) begin
         cpu_write(VEC[i][82:67], VEC[i][66:59]);
         cpu_write(VEC[i][58:43], VEC[i][42:35]);
         prg_probe($sformatf("R5 prg vector %0d", i), VEC[i][34:19], VEC[i][18:0]);
      end
      prg_probe("R9 layout kept", 16'hE000, 19'h7E000);

      // R6 pattern mapping, R4 bit 0 masking
      cpu_write(16'h8000, 8'h00); cpu_write(16'h8001, 8'h0B);
      cpu_write(16'h8000, 8'h01); cpu_write(16'h8001, 8'hFF);
      cpu_write(16'h8000, 8'h02); cpu_write(16'h8001, 8'h11);
      cpu_write(16'h8000, 8'h05); cpu_write(16'h8001, 8'h25);
      chr_probe("R6 big upper 1K", 14'h0400, 18'h02C00);
      chr_probe("R4 big lower 1K", 14'h0123, 18'h02923);
      chr_probe("R6 second big", 14'h0FFF, 18'h3FFFF);
      chr_probe("R6 small reg2", 14'h1010, 18'h04410);
      chr_probe("R6 small reg5", 14'h1C01, 18'h09401);
      check("R6 chr select", 32'(chr_cs), 32'd1);
      ppu_addr = 14'h2000; #1;
      check("R6 chr deselect", 32'(chr_cs), 32'd0);
      cpu_write(16'h8000, 8'h80);
      chr_probe("R2 swapped small low", 14'h0010, 18'h04410);
      chr_probe("R6 swapped big high", 14'h1400, 18'h02C00);
      chr_probe("R6 swapped second big", 14'h1FFF, 18'h3FFFF);

      // R7 mirroring
      cpu_write(16'hA000, 8'h01);
      check("R7 horizontal", 32'(mirror_mode), 32'd1);
      cpu_write(16'hA000, 8'hFE);
      check("R7 vertical", 32'(mirror_mode), 32'd0);
      cpu_write(16'hE000, 8'h01);
      check("R9 mirror kept", 32'(mirror_mode), 32'd0);

      // R8 work RAM protection
      cpu_write(16'hA001, 8'h80);
      ram_probe("R8 read-write", 1'b1, 1'b0, 1'b1, 1'b0);
      ram_probe("R8 read-write wr", 1'b0, 1'b1, 1'b0, 1'b1);
      cpu_write(16'hA001, 8'hC0);
      ram_probe("R8 protect wins", 1'b1, 1'b1, 1'b1, 1'b0);
      cpu_write(16'hA001, 8'h40);
      ram_probe("R8 read-only", 1'b0, 1'b1, 1'b0, 1'b0);
      cpu_write(16'hA001, 8'h00);
      ram_probe("R8 disabled", 1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      cpu_addr = 16'h8000; cpu_rd = 1'b1; #1;
      check("R8 no strobe outside range", {31'd0, wram_rd_en}, 32'd0);
      check("R5 rom select high", 32'(prg_rom_cs), 32'd1);
      cpu_rd = 1'b0;

      // R7 fixed arrangement from the cartridge
      do_reset(2'b11);
      check("R1 reset mirror cfg", 32'(mirror_mode), 32'd3);
      cpu_write(16'hA000, 8'h00);
      check("R7 four-screen kept", 32'(mirror_mode), 32'd3);
      do_reset(2'b10);
      cpu_write(16'hA000, 8'h01);
      check("R7 single-screen kept", 32'(mirror_mode), 32'd2);
      prg_probe("R1 banks cleared", 16'hA000, 19'h00000);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule